// File: doc/BRIEF.md
# Three-Wire Tuner Word Receiver

This block takes serial words from a three-wire bus made of an enable line, a data line and a bit clock. It updates the tuner's band-switch, divider and control registers from those words. The bus lines are sampled in the system clock domain and the block detects their edges there. Data is taken on bit-clock falling edges, and only while the enable line is high.

The receiver counts the bits of each word. The bit count selects which registers are written, when they are written, and how the implied bits are filled in:
- 18-bit and 19-bit words carry the port and divider fields. Their length also sets the ratio select bit.
- 27-bit words also carry the control fields.
- Words of 20 to 26 bits, or longer than 27 bits, raise a length-error pulse.

Top module: `tw3_rx`

## Requirements
- R1: After reset, port_o is 0000, div_o is 0, cp_o is 1, test_o is 001, rsa_o is 1, rsb_o is 1, os_o is 0 and len_err_o is 0.
- R2: Bits are taken only while en_i is high, one per sclk_i falling edge. Clock and data activity while en_i is low changes no output.
- R3: The first four bits of a word are loaded into port_o on the fifth sclk_i rising edge of that word. The first bit goes to port_o[3] and the fourth bit goes to port_o[0].
- R4: When an 18-bit word ends (en_i falls), div_o becomes {0, bits 5..18} with bit 5 as the MSB, and rsa_o becomes 1.
- R5: When a 19-bit word ends, div_o becomes bits 5..19 with bit 5 as the MSB, and rsa_o becomes 0.
- R6: On the twentieth sclk_i rising edge of a word, div_o is loaded from bits 5..19 with bit 5 as the MSB. This happens before the word ends.
- R7: When a 27-bit word ends, the control outputs are loaded from the tail bits: bit 20 to cp_o, bits 21..23 to test_o[2:0], bit 24 to rsa_o, bit 25 to rsb_o and bit 26 to os_o. Bit 27 has no effect.
- R8: cp_o, test_o, rsb_o and os_o change only when a 27-bit word ends. 18-bit and 19-bit words leave them as they were.
- R9: A word shorter than 18 bits leaves div_o, rsa_o and the control outputs unchanged and raises no error.
- R10: A word of 20 to 26 bits, or of more than 27 bits, gives a one-cycle len_err_o pulse in the clock after en_i falls. It leaves rsa_o and the control outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Bus enable line |
| sclk_i | input | 1 | Bus bit clock |
| sdat_i | input | 1 | Bus data line |
| port_o | output | 4 | Band-switch port bits |
| div_o | output | 15 | Programmable divider value |
| cp_o | output | 1 | Charge-pump high-current select |
| test_o | output | 3 | Test mode bits |
| rsa_o | output | 1 | Ratio select A |
| rsb_o | output | 1 | Ratio select B |
| os_o | output | 1 | Tuning output disable |
| len_err_o | output | 1 | Length-error pulse |

## Verification
On every cycle, the embedded assertions check several properties:
- Bit-clock edges and word ends never coincide.
- The port, divider and control registers hold unless their own load condition occurred.
- An 18-bit word always leaves a cleared divider MSB with rsa set.
- Every error pulse follows a word end.

Only the bench scenarios can show that the right bits land in the right fields in the right order. They also show that the ratio select follows word length, that the spare tail bit is ignored, and that the divider is already visible in the middle of a 27-bit word.

// File: rtl/tw3_pkg.sv
package tw3_pkg;
  typedef struct packed {
    logic       cp;
    logic [2:0] test;
    logic       rsa;
    logic       rsb;
    logic       os;
  } ctrl_t;

  localparam int CTRL_TAIL_W = 8;  // cp, test[2:0], rsa, rsb, os, spare
  localparam ctrl_t CTRL_RST = '{cp: 1'b1, test: 3'b001, rsa: 1'b1, rsb: 1'b1, os: 1'b0};
endpackage

// File: rtl/tw3_edge.sv
module tw3_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o,
  output logic done_o
);
  logic sclk_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      en_q   <= en_i;
    end
  end

  assign rise_o = en_i & sclk_i & ~sclk_q;
  assign fall_o = en_i & ~sclk_i & sclk_q;
  assign done_o = en_q & ~en_i;

  // R2
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o, done_o}));
endmodule

// File: rtl/tw3_shift.sv
module tw3_shift #(
  parameter int SH_W  = 15,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fall_i,
  input  logic             sdat_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SH_W-1:0]  sh_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [SH_W-1:0]  sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (fall_i) begin
      sh_q <= {sh_q[SH_W-2:0], sdat_i};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign sh_o  = sh_q;

  // R2
  idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_o == '0 || en_i));
endmodule

// File: rtl/tw3_regs.sv
module tw3_regs
  import tw3_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int DIV_W  = 15,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DIV_W-1:0]  sh_i,
  output logic [PORT_W-1:0] port_o,
  output logic [DIV_W-1:0]  div_o,
  output ctrl_t             ctrl_o,
  output logic              len_err_o
);
  localparam logic [CNT_W-1:0] PORT_CNT  = CNT_W'(PORT_W);
  localparam logic [CNT_W-1:0] LEN_MID   = CNT_W'(PORT_W + DIV_W);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(PORT_W + DIV_W - 1);
  localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(PORT_W + DIV_W + CTRL_TAIL_W);
  localparam int T = CTRL_TAIL_W;

  logic [PORT_W-1:0] port_q;
  logic [DIV_W-1:0]  div_q;
  ctrl_t             ctrl_q;
  logic              err_q;
  logic              is_short, is_mid, is_full, is_bad;

  assign is_short = cnt_i == LEN_SHORT;
  assign is_mid   = cnt_i == LEN_MID;
  assign is_full  = cnt_i == LEN_FULL;
  assign is_bad   = (cnt_i > LEN_MID) && !is_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q <= '0;
      div_q  <= '0;
      ctrl_q <= CTRL_RST;
      err_q  <= 1'b0;
    end else begin
      err_q <= done_i && is_bad;
      if (rise_i && cnt_i == PORT_CNT) port_q <= sh_i[PORT_W-1:0];
      // twentieth rising edge: divider of a long word, length not yet known
      if (rise_i && cnt_i == LEN_MID) div_q <= sh_i;
      if (done_i) begin
        if (is_short) begin
          div_q      <= {1'b0, sh_i[DIV_W-2:0]};
          ctrl_q.rsa <= 1'b1;
        end else if (is_mid) begin
          div_q      <= sh_i;
          ctrl_q.rsa <= 1'b0;
        end else if (is_full) begin
          ctrl_q.cp   <= sh_i[T-1];
          ctrl_q.test <= sh_i[T-2 -: 3];
          ctrl_q.rsa  <= sh_i[T-5];
          ctrl_q.rsb  <= sh_i[T-6];
          ctrl_q.os   <= sh_i[T-7];
        end
      end
    end
  end

  assign port_o    = port_q;
  assign div_o     = div_q;
  assign ctrl_o    = ctrl_q;
  assign len_err_o = err_q;

  // R3
  port_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_i && cnt_i == PORT_CNT) |=> $stable(port_q));
  // R8
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && cnt_i == LEN_FULL) |=> $stable({ctrl_q.cp, ctrl_q.test, ctrl_q.rsb, ctrl_q.os}));
  // R4
  short_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && cnt_i == LEN_SHORT) |=> (!div_q[DIV_W-1] && ctrl_q.rsa));
  // R9
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(done_i && (cnt_i == LEN_SHORT || cnt_i == LEN_MID)) && !(rise_i && cnt_i == LEN_MID))
      |=> $stable(div_q));
  // R10
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $past(done_i));
endmodule

// File: rtl/tw3_rx.sv
module tw3_rx
  import tw3_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int DIV_W  = 15,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic [PORT_W-1:0] port_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              cp_o,
  output logic [2:0]        test_o,
  output logic              rsa_o,
  output logic              rsb_o,
  output logic              os_o,
  output logic              len_err_o
);
  logic             rise, fall, done;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] sh;
  ctrl_t            ctrl;

  tw3_edge u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i), .sclk_i(sclk_i),
    .rise_o(rise), .fall_o(fall), .done_o(done)
  );

  tw3_shift #(.SH_W(DIV_W), .CNT_W(CNT_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .fall_i(fall),
    .sdat_i(sdat_i), .cnt_o(cnt), .sh_o(sh)
  );

  tw3_regs #(.PORT_W(PORT_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .done_i(done),
    .cnt_i(cnt), .sh_i(sh), .port_o(port_o), .div_o(div_o),
    .ctrl_o(ctrl), .len_err_o(len_err_o)
  );

  assign cp_o   = ctrl.cp;
  assign test_o = ctrl.test;
  assign rsa_o  = ctrl.rsa;
  assign rsb_o  = ctrl.rsb;
  assign os_o   = ctrl.os;
endmodule

// File: tb/tb_tw3_rx.sv
`timescale 1ns/1ps
module tb_tw3_rx;
  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0, sclk_i = 1'b0, sdat_i = 1'b0;
  logic [3:0]  port_o;
  logic [14:0] div_o;
  logic        cp_o, rsa_o, rsb_o, os_o, len_err_o;
  logic [2:0]  test_o;

  int n_chk = 0, n_fail = 0, err_seen = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  tw3_rx dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sclk_i(sclk_i), .sdat_i(sdat_i),
    .port_o(port_o), .div_o(div_o), .cp_o(cp_o), .test_o(test_o), .rsa_o(rsa_o),
    .rsb_o(rsb_o), .os_o(os_o), .len_err_o(len_err_o)
  );

  // behavioural reference model
  logic q[$];
  logic [3:0] m_port; logic [14:0] m_div; logic [2:0] m_test;
  logic m_cp, m_rsa, m_rsb, m_os, m_err, m_sclk_p, m_en_p;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete(); m_port = 0; m_div = 0; m_cp = 1; m_test = 3'b001;
      m_rsa = 1; m_rsb = 1; m_os = 0; m_err = 0; m_sclk_p = 0; m_en_p = 0;
    end else begin
      m_err = 0;
      if (m_en_p && !en_i) begin
        if (q.size() == 18) begin
          m_div = 0;
          for (int k = 0; k < 14; k++) m_div[13-k] = q[4+k];
          m_rsa = 1;
        end else if (q.size() == 19) begin
          for (int k = 0; k < 15; k++) m_div[14-k] = q[4+k];
          m_rsa = 0;
        end else if (q.size() == 27) begin
          m_cp = q[19]; m_test = {q[20], q[21], q[22]};
          m_rsa = q[23]; m_rsb = q[24]; m_os = q[25];
        end else if (q.size() >= 20) m_err = 1;
      end
      if (en_i && sclk_i && !m_sclk_p) begin
        if (q.size() == 4) m_port = {q[0], q[1], q[2], q[3]};
        if (q.size() == 19) for (int k = 0; k < 15; k++) m_div[14-k] = q[4+k];
      end
      if (en_i && !sclk_i && m_sclk_p) q.push_back(sdat_i);
      if (!en_i) q.delete();
      m_sclk_p = sclk_i; m_en_p = en_i;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (len_err_o) err_seen++;
    if (rst_ni && !finished) begin
      chk("R3 port vs model", 32'(port_o), 32'(m_port));
      chk("R6 div vs model", 32'(div_o), 32'(m_div));
      chk("R4 rsa vs model", 32'(rsa_o), 32'(m_rsa));
      chk("R7 ctrl vs model", {cp_o, test_o, rsb_o, os_o}, {m_cp, m_test, m_rsb, m_os});
      chk("R10 len_err vs model", 32'(len_err_o), 32'(m_err));
    end
  end

  task automatic send_word(input logic [31:0] w, input int n);
    @(negedge clk_i) en_i = 1;
    repeat (2) @(negedge clk_i);
    for (int i = n - 1; i >= 0; i--) begin
      sdat_i = w[i];
      repeat (2) @(negedge clk_i);
      sclk_i = 1;
      repeat (2) @(negedge clk_i);
      if (n - i == 5) chk("R3 port on fifth rise", 32'(port_o), 32'(w[n-1 -: 4]));
      if (n == 27 && n - i == 20) chk("R6 div on twentieth rise", 32'(div_o), 32'(w[n-5 -: 15]));
      sclk_i = 0;
      repeat (2) @(negedge clk_i);
    end
    en_i = 0;
    repeat (3) @(negedge clk_i);
    sdat_i = 0;
  endtask

  initial begin
    logic [31:0] w;
    logic [14:0] dsave;
    int e0;
    repeat (3) @(negedge clk_i);
    // R1
    chk("R1 port", 32'(port_o), 0);
    chk("R1 div", 32'(div_o), 0);
    chk("R1 ctrl", {cp_o, test_o, rsa_o, rsb_o, os_o}, 7'b1_001_110);
    chk("R1 len_err", 32'(len_err_o), 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    // R2: activity with enable low
    for (int i = 0; i < 10; i++) begin
      sdat_i = i[0]; sclk_i = 1; repeat (2) @(negedge clk_i);
      sclk_i = 0; repeat (2) @(negedge clk_i);
    end
    chk("R2 port idle", 32'(port_o), 0);
    chk("R2 div idle", 32'(div_o), 0);
    chk("R2 ctrl idle", {cp_o, test_o, rsa_o, rsb_o, os_o}, 7'b1_001_110);

    // R4 18-bit word
    w = {14'b0, 4'b1010, 14'h2abc};
    send_word(w, 18);
    chk("R4 div 18-bit", 32'(div_o), 32'({1'b0, w[13:0]}));
    chk("R4 rsa 18-bit", 32'(rsa_o), 1);
    chk("R3 port 18-bit", 32'(port_o), 4'b1010);
    chk("R8 ctrl kept by 18-bit", {cp_o, test_o, rsb_o, os_o}, 6'b1_001_10);

    // R7 27-bit word, spare bit 1
    w = {5'b0, 4'b0110, 15'h5a5a, 8'b0_100_0_0_1_1};
    send_word(w, 27);
    chk("R6 div 27-bit", 32'(div_o), 32'(15'h5a5a));
    chk("R7 ctrl 27-bit", {cp_o, test_o, rsa_o, rsb_o, os_o}, 7'b0_100_001);

    // R5 19-bit word
    w = {13'b0, 4'b0101, 15'h7123};
    send_word(w, 19);
    chk("R5 div 19-bit", 32'(div_o), 32'(15'h7123));
    chk("R5 rsa 19-bit", 32'(rsa_o), 0);
    chk("R8 ctrl kept by 19-bit", {cp_o, test_o, rsb_o, os_o}, 6'b0_100_01);

    // R4 again, divider MSB forced low
    w = {14'b0, 4'b0011, 14'h3fff};
    send_word(w, 18);
    chk("R4 div msb forced", 32'(div_o), 32'(15'h3fff));
    chk("R4 rsa set", 32'(rsa_o), 1);
    chk("R8 ctrl kept again", {cp_o, test_o, rsb_o, os_o}, 6'b0_100_01);

    // R9 short word
    dsave = div_o; e0 = err_seen;
    w = {22'b0, 4'b1100, 6'b101010};
    send_word(w, 10);
    chk("R9 div unchanged", 32'(div_o), 32'(dsave));
    chk("R9 ctrl unchanged", {cp_o, test_o, rsa_o, rsb_o, os_o}, 7'b0_100_101);
    chk("R9 no error", err_seen, e0);
    chk("R3 port short word", 32'(port_o), 4'b1100);

    // R10 22-bit word
    e0 = err_seen;
    w = {10'b0, 4'b1001, 15'h1234, 3'b111};
    send_word(w, 22);
    chk("R10 error pulse 22", err_seen, e0 + 1);
    chk("R10 ctrl unchanged 22", {cp_o, test_o, rsa_o, rsb_o, os_o}, 7'b0_100_101);
    chk("R6 div on long word", 32'(div_o), 32'(w[17:3]));

    // R10 30-bit word
    e0 = err_seen;
    w = {2'b0, 4'b0001, 15'h0f0f, 8'b1_111_1_1_1_1, 3'b000};
    send_word(w, 30);
    chk("R10 error pulse 30", err_seen, e0 + 1);
    chk("R10 ctrl unchanged 30", {cp_o, test_o, rsa_o, rsb_o, os_o}, 7'b0_100_101);

    // R7 27-bit word, spare bit 0
    w = {5'b0, 4'b1111, 15'h0001, 8'b1_011_1_1_0_0};
    send_word(w, 27);
    chk("R7 ctrl spare ignored", {cp_o, test_o, rsa_o, rsb_o, os_o}, 7'b1_011_110);
    chk("R6 div 27-bit second", 32'(div_o), 1);
    chk("R3 port 27-bit", 32'(port_o), 4'b1111);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule